// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correct

This block is the arithmetic and logic datapath of an accumulator-based controller core. It holds an 8-bit accumulator, a carry flag and a half-carry flag in registers. On each clock edge where the enable input is high, it applies one operation, chosen by a 4-bit operation code, to the accumulator and an 8-bit operand. The operand comes from memory or from immediate data, supplied by the surrounding core. Fetch, decode and memory access belong to the surrounding core.

The half-carry flag records the carry out of bit 3 on add with carry and subtract with carry. A later decimal-correct operation uses it to repair packed BCD results. Software pre-biases one addend by 0x66 before a BCD add. The carry convention treats C=1 as "no borrow". The decimal correct then removes 6 from every digit that produced no carry. Set carry and reset carry drive both flags together.

Top module: `acc_alu_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, C and HC to 0 at the clock edge where it is sampled high, and it overrides `op_en`.
- R2: When `op_en` is low at a clock edge, the accumulator, C and HC keep their values.
- R3: Operation code 0 (plain add) writes A + operand modulo 256 to the accumulator and leaves C and HC unchanged.
- R4: Operation code 1 (add with carry) writes the low 8 bits of A + operand + C. C takes the carry out of bit 7 and HC takes the carry out of bit 3.
- R5: Operation code 2 (subtract with carry) writes the low 8 bits of A + (bitwise complement of operand) + C. C takes the carry out of bit 7 (1 means no borrow) and HC takes the carry out of bit 3.
- R6: Operation codes 3, 4 and 5 write A AND operand, A OR operand and A XOR operand respectively, and leave C and HC unchanged.
- R7: Operation codes 6, 7 and 8 write 0, A+1 and A-1 respectively. Increment and decrement wrap modulo 256, and none of the three changes C or HC.
- R8: Operation code 9 rotates right through carry: the old C enters bit 7, bits 7..1 shift down one place, and the old bit 0 becomes C. HC is unchanged.
- R9: Operation code 10 swaps bits 7..4 with bits 3..0 of the accumulator, and leaves C and HC unchanged.
- R10: Operation code 11 sets both C and HC to 1, and operation code 12 clears both to 0. The accumulator is unchanged in both cases.
- R11: Operation code 13 (decimal correct) subtracts 6 from bits 3..0 when HC is 0, and subtracts 6 from bits 7..4 when C is 0. Each 4-bit digit wraps within itself. C and HC are unchanged.
- R12: Operation codes 14 and 15 change neither the accumulator nor either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Apply the selected operation at this edge |
| op_code | input | 4 | Operation select (codes in R3 to R12) |
| operand | input | 8 | Memory or immediate operand |
| acc_q | output | 8 | Accumulator register |
| carry_q | output | 1 | Carry flag register |
| hcarry_q | output | 1 | Half-carry flag register |

## Verification
Every result is due exactly one clock edge after the edge that samples `op_en`, `op_code` and `operand`. This holds for the accumulator, both flags and the reset clear alike, because each output comes straight from a register with no further pipeline. The bench drives its inputs on the falling edge and lets one rising edge apply them. It then compares all three outputs against its reference model at the following falling edge, before any new operation is presented. The bench leaves an idle cycle between operations, so each check sees the effect of exactly one operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned ACC_W  = 8;
  localparam int unsigned HALF_W = ACC_W / 2;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [HALF_W-1:0] half_t;

  localparam half_t DIGIT_FIX = half_t'(6);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBC = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CLR  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_SWAP = 4'd10,
    OP_SETC = 4'd11,
    OP_CLRC = 4'd12,
    OP_DCOR = 4'd13
  } alu_op_e;

  typedef struct packed {
    acc_t sum;
    logic cout;
    logic hout;
  } add_res_t;

  // Two half-width adders chained, so the half carry is a real wire.
  function automatic add_res_t add_chain(acc_t a, acc_t b, logic cin);
    logic [HALF_W:0] lo;
    logic [HALF_W:0] hi;
    add_res_t        r;
    lo = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    hi = {1'b0, a[ACC_W-1:HALF_W]} + {1'b0, b[ACC_W-1:HALF_W]}
       + {{HALF_W{1'b0}}, lo[HALF_W]};
    r.sum  = {hi[HALF_W-1:0], lo[HALF_W-1:0]};
    r.cout = hi[HALF_W];
    r.hout = lo[HALF_W];
    return r;
  endfunction

  // Remove the 6 bias from each digit that did not carry.
  function automatic acc_t dec_adjust(acc_t a, logic c, logic hc);
    half_t lo;
    half_t hi;
    lo = a[HALF_W-1:0];
    hi = a[ACC_W-1:HALF_W];
    if (!hc) lo = lo - DIGIT_FIX;
    if (!c)  hi = hi - DIGIT_FIX;
    return {hi, lo};
  endfunction

  function automatic acc_t swap_halves(acc_t a);
    return {a[HALF_W-1:0], a[ACC_W-1:HALF_W]};
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  alu_op_e op,
  input  acc_t    acc,
  input  acc_t    operand,
  input  logic    c_in,
  input  logic    hc_in,
  output acc_t    sum_o,
  output logic    cout_o,
  output logic    hout_o,
  output acc_t    dcor_o
);

  acc_t     addend;
  logic     carry_in;
  add_res_t add_r;

  // One adder serves add, add with carry, subtract, increment, decrement.
  always_comb begin
    addend   = operand;
    carry_in = 1'b0;
    case (op)
      OP_ADDC: carry_in = c_in;
      OP_SUBC: begin
        addend   = ~operand;
        carry_in = c_in;
      end
      OP_INC:  addend = acc_t'(1);
      OP_DEC:  addend = '1;
      default: ;
    endcase
  end

  assign add_r  = add_chain(acc, addend, carry_in);
  assign sum_o  = add_r.sum;
  assign cout_o = add_r.cout;
  assign hout_o = add_r.hout;
  assign dcor_o = dec_adjust(acc, c_in, hc_in);

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e op,
  input  acc_t    acc,
  input  acc_t    operand,
  input  logic    c_in,
  output acc_t    res_o,
  output logic    rot_c_o
);

  always_comb begin
    res_o = acc;
    case (op)
      OP_AND:  res_o = acc & operand;
      OP_OR:   res_o = acc | operand;
      OP_XOR:  res_o = acc ^ operand;
      OP_CLR:  res_o = '0;
      OP_SWAP: res_o = swap_halves(acc);
      OP_RRC:  res_o = {c_in, acc[ACC_W-1:1]};
      default: ;
    endcase
  end

  assign rot_c_o = acc[0];

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_en,
  input  logic [3:0]       op_code,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry_q,
  output logic             hcarry_q
);

  alu_op_e op_e;
  acc_t    arith_sum;
  logic    arith_cout;
  logic    arith_hout;
  acc_t    dcor_val;
  acc_t    bit_res;
  logic    rot_c;

  acc_t    acc_d;
  logic    c_d;
  logic    hc_d;

  // Named events for the checker.
  logic    is_reserved;
  logic    flag_wr;

  assign op_e        = alu_op_e'(op_code);
  assign is_reserved = (op_code > 4'd13);
  assign flag_wr     = op_en && (op_e == OP_ADDC || op_e == OP_SUBC ||
                                 op_e == OP_RRC  || op_e == OP_SETC ||
                                 op_e == OP_CLRC);

  acc_alu_arith arith_i (
    .op      (op_e),
    .acc     (acc_q),
    .operand (operand),
    .c_in    (carry_q),
    .hc_in   (hcarry_q),
    .sum_o   (arith_sum),
    .cout_o  (arith_cout),
    .hout_o  (arith_hout),
    .dcor_o  (dcor_val)
  );

  acc_alu_bitops bitops_i (
    .op      (op_e),
    .acc     (acc_q),
    .operand (operand),
    .c_in    (carry_q),
    .res_o   (bit_res),
    .rot_c_o (rot_c)
  );

  always_comb begin
    acc_d = acc_q;
    c_d   = carry_q;
    hc_d  = hcarry_q;
    if (op_en && !is_reserved) begin
      case (op_e)
        OP_ADD, OP_INC, OP_DEC: acc_d = arith_sum;
        OP_ADDC, OP_SUBC: begin
          acc_d = arith_sum;
          c_d   = arith_cout;
          hc_d  = arith_hout;
        end
        OP_AND, OP_OR, OP_XOR, OP_CLR, OP_SWAP: acc_d = bit_res;
        OP_RRC: begin
          acc_d = bit_res;
          c_d   = rot_c;
        end
        OP_SETC: begin
          c_d  = 1'b1;
          hc_d = 1'b1;
        end
        OP_CLRC: begin
          c_d  = 1'b0;
          hc_d = 1'b0;
        end
        OP_DCOR: acc_d = dcor_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      carry_q  <= 1'b0;
      hcarry_q <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      carry_q  <= c_d;
      hcarry_q <= hc_d;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             op_en,
  input logic [3:0]       op_code,
  input logic [ACC_W-1:0] operand,
  input logic [ACC_W-1:0] acc_q,
  input logic             carry_q,
  input logic             hcarry_q,
  input logic             flag_wr
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !carry_q && !hcarry_q));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> ($stable(acc_q) && $stable(carry_q) && $stable(hcarry_q)));

  // R3, R6, R7, R9, R11: operations that do not write flags keep them.
  a_r3_flags_kept: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> ($stable(carry_q) && $stable(hcarry_q)));

  a_r4_addc_sum: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_ADDC) |=>
      ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(operand)}
                            + {{ACC_W{1'b0}}, $past(carry_q)})));

  a_r5_subc_sum: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_SUBC) |=>
      ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, ~$past(operand)}
                            + {{ACC_W{1'b0}}, $past(carry_q)})));

  a_r8_rotate: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_RRC) |=>
      (acc_q[ACC_W-1] == $past(carry_q) && carry_q == $past(acc_q[0]) &&
       acc_q[ACC_W-2:0] == $past(acc_q[ACC_W-1:1])));

  a_r9_swap: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_SWAP) |=>
      (acc_q == {$past(acc_q[HALF_W-1:0]), $past(acc_q[ACC_W-1:HALF_W])}));

  a_r10_set_both: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_SETC) |=> (carry_q && hcarry_q && $stable(acc_q)));

  a_r10_clear_both: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code == OP_CLRC) |=> (!carry_q && !hcarry_q && $stable(acc_q)));

  a_r12_reserved_noop: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_code > 4'd13) |=>
      ($stable(acc_q) && $stable(carry_q) && $stable(hcarry_q)));

endmodule

bind acc_alu_unit acc_alu_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_en    (op_en),
  .op_code  (op_code),
  .operand  (operand),
  .acc_q    (acc_q),
  .carry_q  (carry_q),
  .hcarry_q (hcarry_q),
  .flag_wr  (flag_wr)
);

// File: tb/acc_alu_unit_tb_top.sv
`timescale 1ns/1ps
module acc_alu_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_q;
  logic       carry_q;
  logic       hcarry_q;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [7:0] m_a  = 8'd0;
  logic       m_c  = 1'b0;
  logic       m_hc = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .op_en    (op_en),
    .op_code  (op_code),
    .operand  (operand),
    .acc_q    (acc_q),
    .carry_q  (carry_q),
    .hcarry_q (hcarry_q)
  );

  function automatic string tag_of(int op);
    case (op)
      0:        return "R3";
      1:        return "R4";
      2:        return "R5";
      3, 4, 5:  return "R6";
      6, 7, 8:  return "R7";
      9:        return "R8";
      10:       return "R9";
      11, 12:   return "R10";
      13:       return "R11";
      default:  return "R12";
    endcase
  endfunction

  // Reference model written with integer arithmetic.
  task automatic model_step(int op, logic [7:0] v);
    int a = int'(m_a);
    int b = int'(v);
    int ci = int'(m_c);
    int s, lo, hi;
    logic nc;
    case (op)
      0: m_a = 8'((a + b) % 256);
      1, 2: begin
        if (op == 2) b = 255 - b;
        s    = a + b + ci;
        m_hc = ((a % 16) + (b % 16) + ci) > 15;
        m_c  = s > 255;
        m_a  = 8'(s % 256);
      end
      3: m_a = m_a & v;
      4: m_a = m_a | v;
      5: m_a = m_a ^ v;
      6: m_a = 8'd0;
      7: m_a = 8'((a + 1) % 256);
      8: m_a = 8'((a + 255) % 256);
      9: begin
        nc  = m_a[0];
        m_a = {m_c, m_a[7:1]};
        m_c = nc;
      end
      10: m_a = 8'((a % 16) * 16 + a / 16);
      11: begin m_c = 1'b1; m_hc = 1'b1; end
      12: begin m_c = 1'b0; m_hc = 1'b0; end
      13: begin
        lo = a % 16;
        hi = a / 16;
        if (!m_hc) lo = (lo + 10) % 16;
        if (!m_c)  hi = (hi + 10) % 16;
        m_a = 8'(hi * 16 + lo);
      end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    checks++;
    if (acc_q !== m_a || carry_q !== m_c || hcarry_q !== m_hc) begin
      errors++;
      $display("FAIL %s: got a=%02h c=%0b hc=%0b expected a=%02h c=%0b hc=%0b",
               tag, acc_q, carry_q, hcarry_q, m_a, m_c, m_hc);
    end
  endtask

  task automatic check_lit(string tag, logic [7:0] ea, logic ec, logic ehc);
    checks++;
    if (acc_q !== ea || carry_q !== ec || hcarry_q !== ehc) begin
      errors++;
      $display("FAIL %s: got a=%02h c=%0b hc=%0b expected a=%02h c=%0b hc=%0b",
               tag, acc_q, carry_q, hcarry_q, ea, ec, ehc);
    end
  endtask

  // Drive at a falling edge, one rising edge applies it, check at the next fall.
  task automatic apply(bit en, int op, logic [7:0] v);
    @(negedge clk);
    op_en   = en;
    op_code = 4'(op);
    operand = v;
    if (en) model_step(op, v);
    @(negedge clk);
    op_en = 1'b0;
    compare(en ? tag_of(op) : "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst     = 1'b1;
    op_en   = 1'b1;
    op_code = 4'd11;
    operand = 8'hA5;
    repeat (2) @(negedge clk);
    rst   = 1'b0;
    op_en = 1'b0;
    m_a = 8'd0; m_c = 1'b0; m_hc = 1'b0;
    check_lit("R1", 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R3 / R6 / R10 basics
    apply(1, 0, 8'h3C);
    check_lit("R3", 8'h3C, 1'b0, 1'b0);
    apply(1, 11, 8'h00);
    check_lit("R10", 8'h3C, 1'b1, 1'b1);
    apply(1, 0, 8'hF0);
    check_lit("R3", 8'h2C, 1'b1, 1'b1);
    apply(0, 6, 8'h00);
    apply(1, 12, 8'h00);
    check_lit("R10", 8'h2C, 1'b0, 1'b0);

    // R7 wrap at both ends
    apply(1, 6, 8'h00);
    apply(1, 8, 8'h00);
    check_lit("R7", 8'hFF, 1'b0, 1'b0);
    apply(1, 7, 8'h00);
    check_lit("R7", 8'h00, 1'b0, 1'b0);

    // R4 half-carry boundary
    apply(1, 0, 8'h0F);
    apply(1, 1, 8'h01);
    check_lit("R4", 8'h10, 1'b0, 1'b1);

    // R4 / R11: BCD 15 + 27 with 0x66 bias
    apply(1, 6, 8'h00);
    apply(1, 0, 8'h15);
    apply(1, 0, 8'h66);
    apply(1, 12, 8'h00);
    apply(1, 1, 8'h27);
    check_lit("R4", 8'hA2, 1'b0, 1'b1);
    apply(1, 13, 8'h00);
    check_lit("R11", 8'h42, 1'b0, 1'b1);

    // R4 / R11: BCD 99 + 01 gives 00 with decimal carry
    apply(1, 6, 8'h00);
    apply(1, 0, 8'hFF);
    apply(1, 12, 8'h00);
    apply(1, 1, 8'h01);
    check_lit("R4", 8'h00, 1'b1, 1'b1);
    apply(1, 13, 8'h00);
    check_lit("R11", 8'h00, 1'b1, 1'b1);

    // R5 / R11: BCD 42 - 15
    apply(1, 6, 8'h00);
    apply(1, 0, 8'h42);
    apply(1, 11, 8'h00);
    apply(1, 2, 8'h15);
    check_lit("R5", 8'h2D, 1'b1, 1'b0);
    apply(1, 13, 8'h00);
    check_lit("R11", 8'h27, 1'b1, 1'b0);

    // R8 rotate and R9 swap
    apply(1, 0, 8'h5A);
    apply(1, 9, 8'h00);
    apply(1, 9, 8'h00);
    apply(1, 10, 8'h00);
    // R12 reserved codes
    apply(1, 14, 8'hFF);
    apply(1, 15, 8'h33);

    // Constrained random mix
    for (int i = 0; i < 1500; i++) begin
      bit   en = ($urandom_range(0, 7) != 0);
      int   op = int'($urandom_range(0, 15));
      apply(en, op, 8'($urandom));
      if (i == 700) do_reset();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule